// File: doc/BRIEF.md
# Programmable Sample and Integration Timer

This block paces a periodic measurement sensor. It splits time into repeating sample frames and opens an emitter-active (integration) window at the start of each one. Time is counted only in base units, which arrive as single-cycle tick enables. The frame tick stands for 450 µs and the window tick stands for 71.1 µs. The frame length is a linear count multiplied by a power-of-two skip factor. The window length is a power of two. The ratio of window to frame gives the duty cycle, and the frame rate is the output data rate.

Three configuration fields are written through a small write port: period, skip exponent and window exponent. Writes land in holding registers at any time. A running frame copies them only when the next frame starts. An enable input and a shutdown input together park the timer in a passive state, in which no frames and no windows are produced.

Top module: `sample_timer`

## Requirements
- R1: After reset all three outputs are 0, and the holding registers read period 1, skip 0 and window exponent 0.
- R2: A frame lasts (1 + period) × 2^skip frame ticks. frame_start_o pulses for one cycle in the cycle after the frame tick that opens a frame.
- R3: A skip value above 4 is stored as 4, so a frame never exceeds 4096 frame ticks.
- R4: integ_o rises together with frame_start_o. It stays high for 2^len window ticks and then falls, and sample_done_o pulses for one cycle in the same cycle that integ_o falls.
- R5: A window exponent above 11 is stored as 11, which gives a window of 2048 window ticks.
- R6: If a frame ends while integ_o is still high, the window is cut at the frame boundary. sample_done_o pulses in the same cycle as frame_start_o, and the next window starts at once, so integ_o stays high.
- R7: Window ticks are ignored while no window is open. A window tick in the same cycle as the frame tick that opens a window is also ignored.
- R8: A write applies from the next frame start on. The frame and window in progress keep the values latched when they started.
- R9: While en_i is 0 or shutdown_i is 1, all outputs are 0 from the next cycle on, and both counters clear. Writes to the holding registers are still accepted.
- R10: When the timer becomes active again, the first frame opens on the first frame tick.
- R11: Write addresses select the fields: 0 is the period (8 bits), 1 is the skip exponent (wdata_i[3:0]) and 2 is the window exponent (wdata_i[3:0]). Address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Timer enable |
| shutdown_i | input | 1 | Forces passive state when high |
| tick_per_i | input | 1 | Frame base-unit tick (450 µs) |
| tick_int_i | input | 1 | Window base-unit tick (71.1 µs) |
| wr_i | input | 1 | Write strobe for the holding registers |
| addr_i | input | 2 | Field select for a write |
| wdata_i | input | 8 | Write data |
| frame_start_o | output | 1 | One-cycle pulse at each frame start |
| integ_o | output | 1 | Integration window active |
| sample_done_o | output | 1 | One-cycle pulse when a window ends |

## Verification
A wrong frame count shows up at the frame boundary it spoils. frame_start_o then appears early, late or not at all, one cycle after the frame tick in question. A corrupt window counter shows up as integ_o falling, with sample_done_o pulsing, on the wrong window tick. The same fault can also show as a missing clip pulse when the frame boundary arrives. The bench model tracks every cycle, so any such error is caught in the cycle it first reaches a port. Errors in latching or saturation are caught on the first frame that uses the new setting.

// File: rtl/st_pkg.sv
`timescale 1ns/1ps
package st_pkg;
  typedef enum logic [1:0] {
    REG_PERIOD = 2'd0,
    REG_SKIP   = 2'd1,
    REG_LEN    = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/st_cfg_regs.sv
`timescale 1ns/1ps
module st_cfg_regs
  import st_pkg::*;
#(
  parameter int PER_W    = 8,
  parameter int EXP_W    = 4,
  parameter int SKIP_MAX = 4,
  parameter int LEN_MAX  = 11,
  parameter int PER_RST  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [PER_W-1:0] wdata_i,
  output logic [PER_W-1:0] per_o,
  output logic [EXP_W-1:0] skip_o,
  output logic [EXP_W-1:0] len_o
);
  localparam logic [EXP_W-1:0] SKIP_CAP = EXP_W'(SKIP_MAX);
  localparam logic [EXP_W-1:0] LEN_CAP  = EXP_W'(LEN_MAX);

  logic [EXP_W-1:0] wr_exp;
  assign wr_exp = wdata_i[EXP_W-1:0];

  // saturate on write so downstream never sees an illegal exponent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_o  <= PER_W'(PER_RST);
      skip_o <= '0;
      len_o  <= '0;
    end else if (wr_i) begin
      case (reg_sel_e'(addr_i))
        REG_PERIOD: per_o  <= wdata_i;
        REG_SKIP:   skip_o <= (wr_exp > SKIP_CAP) ? SKIP_CAP : wr_exp;
        REG_LEN:    len_o  <= (wr_exp > LEN_CAP) ? LEN_CAP : wr_exp;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/st_frame_ctr.sv
`timescale 1ns/1ps
module st_frame_ctr #(
  parameter int PER_W    = 8,
  parameter int EXP_W    = 4,
  parameter int SKIP_MAX = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [EXP_W-1:0] skip_i,
  output logic             start_o,
  output logic             frame_start_o
);
  localparam int CNT_W = PER_W + 1 + SKIP_MAX;

  logic [PER_W-1:0] per_q;
  logic [EXP_W-1:0] skip_q;
  logic             running_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] flen;

  assign flen    = (CNT_W'(per_q) + CNT_W'(1)) << skip_q;
  assign start_o = run_i & tick_i & (~running_q | (cnt_q == flen));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q         <= '0;
      skip_q        <= '0;
      running_q     <= 1'b0;
      cnt_q         <= '0;
      frame_start_o <= 1'b0;
    end else if (!run_i) begin
      running_q     <= 1'b0;
      cnt_q         <= '0;
      frame_start_o <= 1'b0;
    end else begin
      frame_start_o <= start_o;
      if (start_o) begin
        running_q <= 1'b1;
        cnt_q     <= CNT_W'(1);
        per_q     <= per_i;
        skip_q    <= skip_i;
      end else if (tick_i) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/st_integ_ctr.sv
`timescale 1ns/1ps
module st_integ_ctr #(
  parameter int EXP_W   = 4,
  parameter int LEN_MAX = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [EXP_W-1:0] len_i,
  output logic             integ_o,
  output logic             done_o
);
  localparam int CW = LEN_MAX + 1;

  logic [EXP_W-1:0] len_q;
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    target;
  logic             end_nat;
  logic             clip;

  assign target  = CW'(1) << len_q;
  assign end_nat = integ_o & tick_i & ~start_i & ((cnt_q + CW'(1)) == target);
  // frame boundary while window still open: cut it there
  assign clip    = integ_o & start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q   <= '0;
      cnt_q   <= '0;
      integ_o <= 1'b0;
      done_o  <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      integ_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= end_nat | clip;
      if (start_i) begin
        integ_o <= 1'b1;
        cnt_q   <= '0;
        len_q   <= len_i;
      end else if (end_nat) begin
        integ_o <= 1'b0;
      end else if (integ_o & tick_i) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/sample_timer.sv
`timescale 1ns/1ps
module sample_timer #(
  parameter int PER_W    = 8,
  parameter int EXP_W    = 4,
  parameter int SKIP_MAX = 4,
  parameter int LEN_MAX  = 11,
  parameter int PER_RST  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             shutdown_i,
  input  logic             tick_per_i,
  input  logic             tick_int_i,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [PER_W-1:0] wdata_i,
  output logic             frame_start_o,
  output logic             integ_o,
  output logic             sample_done_o
);
  logic             run;
  logic             start;
  logic [PER_W-1:0] per_sh;
  logic [EXP_W-1:0] skip_sh;
  logic [EXP_W-1:0] len_sh;

  assign run = en_i & ~shutdown_i;

  st_cfg_regs #(
    .PER_W(PER_W), .EXP_W(EXP_W), .SKIP_MAX(SKIP_MAX),
    .LEN_MAX(LEN_MAX), .PER_RST(PER_RST)
  ) u_cfg (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .per_o(per_sh), .skip_o(skip_sh), .len_o(len_sh)
  );

  st_frame_ctr #(.PER_W(PER_W), .EXP_W(EXP_W), .SKIP_MAX(SKIP_MAX)) u_frame (
    .clk_i, .rst_ni, .run_i(run), .tick_i(tick_per_i),
    .per_i(per_sh), .skip_i(skip_sh),
    .start_o(start), .frame_start_o
  );

  st_integ_ctr #(.EXP_W(EXP_W), .LEN_MAX(LEN_MAX)) u_integ (
    .clk_i, .rst_ni, .run_i(run), .start_i(start), .tick_i(tick_int_i),
    .len_i(len_sh), .integ_o, .done_o(sample_done_o)
  );
endmodule

// File: rtl/sample_timer_chk.sv
`timescale 1ns/1ps
module sample_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic shutdown_i,
  input logic tick_per_i,
  input logic tick_int_i,
  input logic frame_start_o,
  input logic integ_o,
  input logic sample_done_o
);
  assert_passive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && !shutdown_i) |=> (!frame_start_o && !integ_o && !sample_done_o));

  assert_start_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> $past(tick_per_i));

  assert_window_opens_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> integ_o);

  assert_done_on_close_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(integ_o) && $past(en_i && !shutdown_i)) |-> sample_done_o);

  assert_clip_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && $past(integ_o)) |-> sample_done_o);

  assert_done_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_done_o |-> ($past(tick_int_i) || $past(tick_per_i)));
endmodule

bind sample_timer sample_timer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .shutdown_i(shutdown_i),
  .tick_per_i(tick_per_i), .tick_int_i(tick_int_i),
  .frame_start_o(frame_start_o), .integ_o(integ_o), .sample_done_o(sample_done_o)
);

// File: tb/tb_sample_timer.sv
`timescale 1ns/1ps
module tb_sample_timer;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       en_i = 1'b0, sd_i = 1'b0, tp_i = 1'b0, ti_i = 1'b0, wr_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wd_i = 8'd0;
  logic       fs_o, ig_o, dn_o;

  sample_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_i), .shutdown_i(sd_i),
    .tick_per_i(tp_i), .tick_int_i(ti_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wd_i), .frame_start_o(fs_o), .integ_o(ig_o), .sample_done_o(dn_o)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    cyc;
    bit    fs;
    bit    ig;
    bit    dn;
    string req;
  } exp_t;

  exp_t  q[$];
  int    cyc = 0;
  int    total = 0, bad = 0;
  bit    en_v = 1'b1, sd_v = 1'b0;
  string cur_req = "R1";
  // reference state: remaining frame ticks, remaining window ticks
  int    fl = 0, wl = 0, m_p = 1, m_s = 0, m_l = 0;
  bit    act = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act_v, int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act_v, exp_v, cyc);
    end
  endtask

  task automatic step(bit tp, bit ti, bit we = 1'b0, logic [1:0] a = 2'd0, logic [7:0] d = 8'd0);
    exp_t e;
    bit   e_fs, e_dn, run;
    @(negedge clk);
    tp_i = tp; ti_i = ti; wr_i = we; addr_i = a; wd_i = d;
    en_i = en_v; sd_i = sd_v;
    run  = en_v && !sd_v;
    e_fs = 1'b0; e_dn = 1'b0;
    if (!run) begin
      fl = 0; wl = 0; act = 1'b0;
    end else if (tp && fl == 0) begin
      e_fs = 1'b1;
      e_dn = act;
      act  = 1'b1;
      wl   = 1 << m_l;
      fl   = ((1 + m_p) << m_s) - 1;
    end else begin
      if (tp) fl--;
      if (act && ti) begin
        wl--;
        if (wl == 0) begin act = 1'b0; e_dn = 1'b1; end
      end
    end
    if (we) begin
      case (a)
        2'd0: m_p = d;
        2'd1: m_s = (d[3:0] > 4) ? 4 : d[3:0];
        2'd2: m_l = (d[3:0] > 11) ? 11 : d[3:0];
        default: ;
      endcase
    end
    e.cyc = cyc + 1; e.fs = e_fs; e.ig = act; e.dn = e_dn; e.req = cur_req;
    q.push_back(e);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    step(1'b0, 1'b0, 1'b1, a, d);
  endtask

  task automatic pattern(int n, int kp, int ki);
    for (int i = 0; i < n; i++)
      step(kp > 0 && (i % kp) == 0, ki > 0 && (i % ki) == ki - 1);
  endtask

  // monitor: compare every produced cycle against the queued expectation
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].cyc == cyc) begin
      exp_t e;
      e = q.pop_front();
      chk(fs_o === e.fs, e.req, "frame_start_o", int'(fs_o), int'(e.fs));
      chk(ig_o === e.ig, e.req, "integ_o", int'(ig_o), int'(e.ig));
      chk(dn_o === e.dn, e.req, "sample_done_o", int'(dn_o), int'(e.dn));
    end
  end

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fs_o == 1'b0, "R1", "reset frame_start_o", int'(fs_o), 0);
    chk(ig_o == 1'b0, "R1", "reset integ_o", int'(ig_o), 0);
    chk(dn_o == 1'b0, "R1", "reset sample_done_o", int'(dn_o), 0);

    cur_req = "R1";
    step(1, 0); step(0, 1); step(0, 0); step(1, 0); step(1, 0); step(0, 1);

    cur_req = "R2";
    wr(2'd0, 8'd2); wr(2'd2, 8'd1);
    pattern(30, 2, 3);

    cur_req = "R3";
    wr(2'd0, 8'd0); wr(2'd1, 8'd9);
    pattern(70, 2, 0);

    cur_req = "R5";
    wr(2'd0, 8'd255); wr(2'd1, 8'd4); wr(2'd2, 8'd15);
    pattern(40, 1, 0);
    pattern(2060, 0, 1);

    cur_req = "R9";
    en_v = 1'b0;
    wr(2'd0, 8'd1); wr(2'd1, 8'd0); wr(2'd2, 8'd3);
    pattern(8, 1, 1);

    cur_req = "R10";
    en_v = 1'b1;
    pattern(3, 0, 1);
    step(1, 0);

    cur_req = "R6";
    pattern(24, 3, 2);

    cur_req = "R7";
    wr(2'd2, 8'd1);
    en_v = 1'b0; step(0, 0);
    en_v = 1'b1;
    step(1, 1); step(0, 1); step(0, 1); step(0, 1); step(0, 1);
    step(1, 0); step(1, 1);

    cur_req = "R8";
    step(0, 0, 1'b1, 2'd0, 8'd4);
    step(1, 0); step(1, 0);
    pattern(12, 1, 0);

    cur_req = "R11";
    wr(2'd3, 8'hFF); wr(2'd1, 8'hF1);
    pattern(14, 1, 0);

    cur_req = "R9";
    sd_v = 1'b1;
    pattern(6, 1, 1);
    sd_v = 1'b0;
    pattern(8, 1, 1);

    step(0, 0); step(0, 0);
    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R2", "scoreboard drained", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule